// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns characters into an asynchronous serial stream on a single output line. Software reaches it through a small register file. A control register gates the line. A line-format register sets word length, parity and stop bits, and also commits the staged baud divisor. A pair of divisor registers sets the bit rate. A flag register shows the queue state and the activity state. A data register takes characters to send.

Bit timing is oversampled. A baud tick fires every D clocks, and a fractional accumulator stretches the odd tick period by one clock so that the average period is D + F/64. Each serial bit lasts sixteen ticks. Characters wait in a shallow queue. When the queue is turned off it shrinks to a single holding slot. Divisor writes take effect only when the line-format register is written, so a new rate and a new format always start together.

Register addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | line format |
| 2 | integer divisor |
| 3 | fractional divisor |
| 4 | flags |
| 5 | data |

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line is high, every writable register reads 0, and the flag register (address 4) reads 0x80. In the flag register, bit 7 means queue empty, bit 5 means queue full and bit 3 means busy.
- R2: A frame starts only while control bit 0 (block enable) and control bit 8 (transmit enable) are both set; otherwise the line stays high and queued characters wait. Clearing either bit during a frame drops that frame and forces the line high. Control bit 9 is stored and reads back, but it has no effect on the line.
- R3: A frame is one low start bit, then the data bits LSB first, then the optional parity bit, then the high stop bits; between frames the line is high.
- R4: Line-format bits 6:5 hold the word length minus five (00 means 5 bits, 11 means 8 bits). Data bits above the word length are ignored.
- R5: Line-format bit 1 enables a parity bit. Bit 2 set selects even parity, where the parity bit is the XOR of the data bits. Bit 2 clear selects odd parity, the inverse of that XOR.
- R6: Line-format bit 3 set sends two stop bits; clear sends one.
- R7: Every bit lasts 16 baud ticks. For an integer divisor D and a fractional divisor F (6 bits, units of 1/64), tick k ends T(k) = k·D + floor((k−1)·F/64) clocks after the start bit begins. A frame of n bits therefore ends at T(16n).
- R8: Values written to the divisor registers (addresses 2 and 3) read back at once. They drive the bit timing only after the next write to the line-format register, even when that write does not change the format.
- R9: With line-format bit 4 set, the queue holds 16 characters in order. The full flag rises at 16, and a data write while full is dropped.
- R10: With line-format bit 4 clear, the queue holds one character. The full flag rises after one write, and a second write before the character leaves is dropped.
- R11: The busy flag is high while a frame is in progress or a character is queued. It falls at the end of the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the baud reference |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| txd | output | 1 | Serial output line, idles high |

## Verification
The assertions assume that software never writes an integer divisor of zero, since such a divisor would hold a frame in its start bit forever. They also assume that register writes arrive as single-cycle strobes. The stimulus keeps to these rules by drawing integer divisors only from 2 to 5. It changes the format and the divisors only while the transmitter is off or idle, and it queues characters before the enable is raised, so frame start edges are predictable. Random formats and fractional divisors are mixed with directed cases for staging, the queue limits, aborts and the enable bits.

// File: rtl/uart_tx_pkg.sv
// Shared types and field positions for the UART transmit framer.
// Assumes a 3-bit register address space and at most 8 data bits per character.
package uart_tx_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_LINE = 3'd1,
        A_DIVI = 3'd2,
        A_DIVF = 3'd3,
        A_FLAG = 3'd4,
        A_DATA = 3'd5
    } reg_addr_e;

    // Control register bit positions
    localparam int CTRL_UART_EN = 0;
    localparam int CTRL_TX_EN   = 8;
    localparam int CTRL_RX_EN   = 9;

    // Line-format register bit positions
    localparam int LINE_PAR_EN   = 1;
    localparam int LINE_PAR_EVEN = 2;
    localparam int LINE_TWO_STOP = 3;
    localparam int LINE_FIFO_EN  = 4;
    localparam int LINE_WLEN_LO  = 5;

    // Flag register bit positions
    localparam int FLAG_BUSY = 3;
    localparam int FLAG_FULL = 5;
    localparam int FLAG_EMPT = 7;

    typedef struct packed {
        logic       par_en;
        logic       par_even;
        logic       two_stop;
        logic       fifo_en;
        logic [1:0] wlen_m5;
    } line_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_state_e;

endpackage

// File: rtl/uart_tx_regs.sv
// Register file: control, line format, staged and active divisors, flags, data strobe.
// Assumes BUS_W is at least 16 and at least DIV_W. Divisors commit on any line-format write.
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 6,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              st_busy,
    input  logic              st_full,
    input  logic              st_empty,
    output logic [BUS_W-1:0]  rdata,
    output logic              uart_en,
    output logic              tx_en,
    output line_cfg_t         line_cfg,
    output logic [DIV_W-1:0]  div_int_act,
    output logic [FRAC_W-1:0] div_frac_act,
    output logic              line_wr,
    output logic              data_push,
    output logic [CHAR_W-1:0] data_char
);

    logic              rx_en;
    logic [DIV_W-1:0]  div_int_stg;
    logic [FRAC_W-1:0] div_frac_stg;

    assign line_wr   = wr_en && (addr == A_LINE);
    assign data_push = wr_en && (addr == A_DATA);
    assign data_char = wdata[CHAR_W-1:0];

    // Control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uart_en <= 1'b0;
            tx_en   <= 1'b0;
            rx_en   <= 1'b0;
        end else if (wr_en && addr == A_CTRL) begin
            uart_en <= wdata[CTRL_UART_EN];
            tx_en   <= wdata[CTRL_TX_EN];
            rx_en   <= wdata[CTRL_RX_EN];
        end
    end

    // Line-format register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cfg <= '0;
        end else if (line_wr) begin
            line_cfg.par_en   <= wdata[LINE_PAR_EN];
            line_cfg.par_even <= wdata[LINE_PAR_EVEN];
            line_cfg.two_stop <= wdata[LINE_TWO_STOP];
            line_cfg.fifo_en  <= wdata[LINE_FIFO_EN];
            line_cfg.wlen_m5  <= wdata[LINE_WLEN_LO+1:LINE_WLEN_LO];
        end
    end

    // Staged divisor writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_int_stg  <= '0;
            div_frac_stg <= '0;
        end else if (wr_en) begin
            if (addr == A_DIVI) div_int_stg  <= wdata[DIV_W-1:0];
            if (addr == A_DIVF) div_frac_stg <= wdata[FRAC_W-1:0];
        end
    end

    // Commit staged divisors when line format is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_int_act  <= '0;
            div_frac_act <= '0;
        end else if (line_wr) begin
            div_int_act  <= div_int_stg;
            div_frac_act <= div_frac_stg;
        end
    end

    // Read-data multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTRL_UART_EN] = uart_en;
                rdata[CTRL_TX_EN]   = tx_en;
                rdata[CTRL_RX_EN]   = rx_en;
            end
            A_LINE: begin
                rdata[LINE_PAR_EN]                    = line_cfg.par_en;
                rdata[LINE_PAR_EVEN]                  = line_cfg.par_even;
                rdata[LINE_TWO_STOP]                  = line_cfg.two_stop;
                rdata[LINE_FIFO_EN]                   = line_cfg.fifo_en;
                rdata[LINE_WLEN_LO+1:LINE_WLEN_LO]    = line_cfg.wlen_m5;
            end
            A_DIVI: rdata = BUS_W'(div_int_stg);
            A_DIVF: rdata = BUS_W'(div_frac_stg);
            A_FLAG: begin
                rdata[FLAG_BUSY] = st_busy;
                rdata[FLAG_FULL] = st_full;
                rdata[FLAG_EMPT] = st_empty;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_tx_baud.sv
// Baud tick generator: one tick every D clocks, plus one extra clock after each
// carry of a 1/64-unit fractional accumulator. Restarts from phase zero when idle.
// Assumes the integer divisor is nonzero; zero yields no ticks.
module uart_tx_baud #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);

    logic [DIV_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic              extra;
    logic [DIV_W:0]    limit;
    logic [FRAC_W:0]   acc_sum;

    assign limit   = {1'b0, div_int} + (DIV_W+1)'(extra) - (DIV_W+1)'(1);
    assign tick    = run && ({1'b0, cnt} == limit);
    assign acc_sum = {1'b0, acc} + {1'b0, div_frac};

    // Period counter and fractional accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            acc   <= '0;
            extra <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            acc   <= acc_sum[FRAC_W-1:0];
            extra <= acc_sum[FRAC_W];
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/uart_tx_fifo.sv
// Transmit holding queue with a runtime capacity of DEPTH entries or one entry.
// Writes beyond the current capacity are refused. Assumes DEPTH >= 2.
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         deep_en,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap;
    logic             wr_ok, rd_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign cap   = deep_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full  = (cnt >= cap);
    assign empty = (cnt == '0);
    assign wr_ok = push && !full;
    assign rd_ok = pop && !empty;
    assign dout  = mem[rp];

    // Storage write
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= din;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= ptr_next(wp);
            if (rd_ok) rp <= ptr_next(rp);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_shift.sv
// Frame serialiser: start, data LSB first, optional parity, one or two stops.
// The format is latched per frame. Dropping the enable aborts to idle.
// Assumes one tick input per oversample period from the baud generator.
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              have_data,
    input  logic [CHAR_W-1:0] din,
    input  line_cfg_t         cfg,
    output logic              pop,
    output logic              active,
    output logic              ser_txd
);

    localparam int SUB_W = $clog2(OVS);
    localparam int IDX_W = $clog2(CHAR_W);

    tx_state_e         state;
    logic [SUB_W-1:0]  sub;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par;
    logic              stop2;
    logic              bit_end;
    line_cfg_t         fcfg;

    assign last_idx = IDX_W'(fcfg.wlen_m5) + IDX_W'(4);
    assign bit_end  = tick && (sub == SUB_W'(OVS - 1));
    assign pop      = enable && (state == S_IDLE) && have_data;
    assign active   = (state != S_IDLE);

    // Frame sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= S_IDLE;
            sub   <= '0;
            idx   <= '0;
            shreg <= '0;
            par   <= 1'b0;
            stop2 <= 1'b0;
            fcfg  <= '0;
        end else if (state == S_IDLE) begin
            if (have_data) begin
                state <= S_START;
                shreg <= din;
                fcfg  <= cfg;
                sub   <= '0;
                idx   <= '0;
                par   <= 1'b0;
                stop2 <= 1'b0;
            end
        end else if (tick) begin
            sub <= bit_end ? '0 : sub + SUB_W'(1);
            if (bit_end) begin
                case (state)
                    S_START: state <= S_DATA;
                    S_DATA: begin
                        par   <= par ^ shreg[0];
                        shreg <= shreg >> 1;
                        if (idx == last_idx) state <= fcfg.par_en ? S_PAR : S_STOP;
                        else                 idx   <= idx + IDX_W'(1);
                    end
                    S_PAR:  state <= S_STOP;
                    S_STOP: begin
                        if (fcfg.two_stop && !stop2) stop2 <= 1'b1;
                        else                         state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Line level for the current frame position
    always_comb begin
        case (state)
            S_START: ser_txd = 1'b0;
            S_DATA:  ser_txd = shreg[0];
            S_PAR:   ser_txd = fcfg.par_even ? par : ~par;
            default: ser_txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_framer.sv
// Top level of the UART transmit framer: register file, holding queue,
// baud tick generator and frame serialiser. The line is held high unless
// both the block enable and the transmit enable are set.
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int DIV_W      = 16,
    parameter int FRAC_W     = 6,
    parameter int CHAR_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              txd
);

    logic              uart_en, tx_en, line_wr, data_push;
    logic [CHAR_W-1:0] data_char, fifo_dout;
    line_cfg_t         line_cfg;
    logic [DIV_W-1:0]  div_int_act;
    logic [FRAC_W-1:0] div_frac_act;
    logic              fifo_full, fifo_empty, ser_pop, ser_active, ser_txd;
    logic              tick, line_on, busy;

    assign line_on = uart_en && tx_en;
    assign busy    = ser_active || !fifo_empty;
    assign txd     = line_on ? ser_txd : 1'b1;

    uart_tx_regs #(
        .BUS_W(BUS_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W), .CHAR_W(CHAR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .st_busy(busy), .st_full(fifo_full), .st_empty(fifo_empty),
        .rdata(reg_rdata), .uart_en(uart_en), .tx_en(tx_en), .line_cfg(line_cfg),
        .div_int_act(div_int_act), .div_frac_act(div_frac_act),
        .line_wr(line_wr), .data_push(data_push), .data_char(data_char)
    );

    uart_tx_fifo #(
        .DEPTH(FIFO_DEPTH), .W(CHAR_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .deep_en(line_cfg.fifo_en),
        .push(data_push), .din(data_char), .pop(ser_pop),
        .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
    );

    uart_tx_baud #(
        .DIV_W(DIV_W), .FRAC_W(FRAC_W)
    ) u_baud (
        .clk(clk), .rst_n(rst_n), .run(ser_active),
        .div_int(div_int_act), .div_frac(div_frac_act), .tick(tick)
    );

    uart_tx_shift #(
        .CHAR_W(CHAR_W), .OVS(OVS)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .enable(line_on), .tick(tick),
        .have_data(!fifo_empty), .din(fifo_dout), .cfg(line_cfg),
        .pop(ser_pop), .active(ser_active), .ser_txd(ser_txd)
    );

endmodule

// File: rtl/uart_tx_framer_chk.sv
// Property checker for the UART transmit framer, attached by bind.
// Observes the enables, the queue flags, the serialiser activity and the line.
module uart_tx_framer_chk #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              uart_en,
    input logic              tx_en,
    input logic              txd,
    input logic              ser_active,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              data_push,
    input logic              line_wr,
    input logic [DIV_W-1:0]  div_int_act,
    input logic [FRAC_W-1:0] div_frac_act
);

    // R2
    off_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(uart_en && tx_en) |-> txd);

    // R2
    off_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(uart_en && tx_en) |=> !ser_active);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_active) |-> !txd);

    // R3
    end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_active) |-> txd);

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wr |=> ($stable(div_int_act) && $stable(div_frac_act)));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    // R9
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_push && fifo_empty) |=> !fifo_empty);

endmodule

bind uart_tx_framer uart_tx_framer_chk #(
    .DIV_W(DIV_W), .FRAC_W(FRAC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .tx_en(tx_en), .txd(txd),
    .ser_active(ser_active), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .data_push(data_push), .line_wr(line_wr),
    .div_int_act(div_int_act), .div_frac_act(div_frac_act)
);

// File: tb/uart_tx_framer_tb.sv
// Self-checking bench: directed corner cases plus seeded random formats.
module uart_tx_framer_tb;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd4;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        txd;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    uart_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd4;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd4;
    endtask

    // Clock count from start-bit edge to the end of tick k (R7)
    function automatic int tk(input int k, input int d, input int f);
        if (k == 0) return 0;
        return k * d + ((k - 1) * f) / 64;
    endfunction

    function automatic bit exp_bit(input int b, input logic [7:0] ch, input int wl,
                                   input bit pe, input bit ev);
        logic [7:0] m;
        bit p;
        if (b == 0) return 1'b0;
        if (b <= wl) return ch[b-1];
        if (pe && b == wl + 1) begin
            m = ch & 8'((1 << wl) - 1);
            p = ^m;
            return ev ? p : ~p;
        end
        return 1'b1;
    endfunction

    function automatic string bit_req(input int b, input int wl, input bit pe);
        if (b == 0) return "R3";
        if (b <= wl) return "R4";
        if (pe && b == wl + 1) return "R5";
        return "R6";
    endfunction

    function automatic logic [15:0] line_word(input int wl, input bit pe, input bit ev,
                                              input bit two, input bit fe);
        return 16'({2'(wl - 5), fe, two, ev, pe, 1'b0});
    endfunction

    // Capture one frame from its falling edge; optionally time it via the busy flag
    task automatic run_frame(input logic [7:0] ch, input int wl, input bit pe, input bit ev,
                             input bit two, input int d, input int f, input bit want_dur);
        int nb;
        int n;
        int guard;
        nb = 1 + wl + (pe ? 1 : 0) + (two ? 2 : 1);
        guard = 0;
        @(negedge clk);
        while (txd !== 1'b0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (txd !== 1'b0) begin
            check(1'b0, "R3 start edge", int'(txd), 0);
            return;
        end
        n = 0;
        for (int b = 0; b < nb; b++) begin
            while (n < tk(16 * b + 8, d, f)) begin
                @(negedge clk);
                n++;
            end
            check(txd === exp_bit(b, ch, wl, pe, ev), bit_req(b, wl, pe),
                  int'(txd), int'(exp_bit(b, ch, wl, pe, ev)));
        end
        if (want_dur) begin
            while (reg_rdata[3] === 1'b1 && n < 100000) begin
                @(negedge clk);
                n++;
            end
            check(n == tk(16 * nb, d, f), "R7 frame length", n, tk(16 * nb, d, f));
        end
    endtask

    task automatic hold_high(input int cycles, input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    // Watchdog
    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  q [16];
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(txd === 1'b1, "R1 idle line", int'(txd), 1);
        rd(3'd4, v); check(v == 16'h0080, "R1 flags", v, 16'h0080);
        rd(3'd0, v); check(v == 16'h0000, "R1 control", v, 0);
        rd(3'd1, v); check(v == 16'h0000, "R1 line", v, 0);

        // R10 single holding slot, R11 busy while queued, R2 gating
        wr(3'd2, 16'd3);
        wr(3'd1, line_word(8, 0, 0, 0, 0));
        rd(3'd1, v); check(v == 16'h0060, "R4 line readback", v, 16'h0060);
        wr(3'd5, 16'h00A5);
        rd(3'd4, v); check(v == 16'h0028, "R10 full after one", v, 16'h0028);
        wr(3'd5, 16'h003C);
        hold_high(150, "R2 both off");
        wr(3'd0, 16'h0001);
        hold_high(100, "R2 block only");
        wr(3'd0, 16'h0100);
        hold_high(100, "R2 tx only");
        wr(3'd0, 16'h0300);
        hold_high(100, "R2 receive bit no effect");
        rd(3'd0, v); check(v == 16'h0300, "R2 control readback", v, 16'h0300);
        wr(3'd0, 16'h0101);
        run_frame(8'hA5, 8, 0, 0, 0, 3, 0, 1);
        hold_high(200, "R10 second write dropped");
        rd(3'd4, v); check(v == 16'h0080, "R11 idle flags", v, 16'h0080);

        // R8 divisor staging
        wr(3'd2, 16'd5);
        rd(3'd2, v); check(v == 16'd5, "R8 staged readback", v, 5);
        wr(3'd5, 16'h000F);
        run_frame(8'h0F, 8, 0, 0, 0, 3, 0, 1);
        wr(3'd1, line_word(8, 0, 0, 0, 0));
        wr(3'd5, 16'h000F);
        run_frame(8'h0F, 8, 0, 0, 0, 5, 0, 1);

        // R4 five-bit word ignores upper data bits
        wr(3'd1, line_word(5, 0, 0, 0, 0));
        wr(3'd5, 16'h00FF);
        run_frame(8'hFF, 5, 0, 0, 0, 5, 0, 1);

        // R5 R6 R7 seeded random formats and fractional divisors
        for (int it = 0; it < 12; it++) begin
            int wl, d, f, cnt;
            bit pe, ev, two;
            logic [7:0] chs [3];
            wl  = 5 + int'($urandom_range(3, 0));
            pe  = 1'($urandom_range(1, 0));
            ev  = 1'($urandom_range(1, 0));
            two = 1'($urandom_range(1, 0));
            d   = 2 + int'($urandom_range(3, 0));
            f   = int'($urandom_range(63, 0));
            cnt = 1 + int'($urandom_range(2, 0));
            if (it == 0) begin pe = 1; ev = 1; end
            if (it == 1) begin pe = 1; ev = 0; end
            if (it == 2) f = 63;
            wr(3'd0, 16'h0000);
            wr(3'd2, 16'(d));
            wr(3'd3, 16'(f));
            wr(3'd1, line_word(wl, pe, ev, two, 1));
            for (int c = 0; c < cnt; c++) begin
                chs[c] = 8'($urandom);
                wr(3'd5, {8'h00, chs[c]});
            end
            wr(3'd0, 16'h0101);
            for (int c = 0; c < cnt; c++)
                run_frame(chs[c], wl, pe, ev, two, d, f, c == cnt - 1);
        end

        // R9 deep queue fills at sixteen, overflow dropped, order kept
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'd2);
        wr(3'd3, 16'd0);
        wr(3'd1, line_word(8, 0, 0, 0, 1));
        for (int c = 0; c < 16; c++) begin
            q[c] = 8'($urandom);
            if (c == 14) begin
                rd(3'd4, v); check(v == 16'h0008, "R9 not full at 14", v, 16'h0008);
            end
            wr(3'd5, {8'h00, q[c]});
        end
        rd(3'd4, v); check(v == 16'h0028, "R9 full at 16", v, 16'h0028);
        wr(3'd5, 16'h00E7);
        wr(3'd0, 16'h0101);
        for (int c = 0; c < 16; c++)
            run_frame(q[c], 8, 0, 0, 0, 2, 0, c == 15);
        hold_high(300, "R9 overflow write dropped");

        // R2 abort mid-frame
        wr(3'd2, 16'd3);
        wr(3'd1, line_word(8, 0, 0, 0, 1));
        wr(3'd5, 16'h0000);
        repeat (100) @(negedge clk);
        check(txd === 1'b0, "R3 data low mid-frame", int'(txd), 0);
        wr(3'd0, 16'h0000);
        hold_high(50, "R2 abort forces high");
        rd(3'd4, v); check(v == 16'h0080, "R11 busy clears on abort", v, 16'h0080);
        wr(3'd0, 16'h0101);
        hold_high(600, "R2 aborted frame not resent");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule